// File: doc/BRIEF.md
# Shared-Address Serial Slave with Subaddress-Gated Data Acknowledge

This block is the two-wire serial (I2C) slave front end of a display driver. It watches SCL and SDA on its own system clock. It finds START and STOP conditions and compares the first byte of each transfer with a 7-bit address. The upper six bits of that address are fixed at `011110`, and a strap pin supplies the lowest bit. Several drivers can therefore share one address while a second group uses the neighbouring one.

The block splits acknowledgement between two groups of devices. Every device on the shared address acknowledges the address byte and each command byte together. Display-data bytes are acknowledged only by the device whose four-bit hardware subaddress matches the selection held by the external command decoder. The most significant bit of each command byte is a continuation flag. When a command arrives with that flag clear, every later byte in the transfer is display data.

Each received byte is handed on with a strobe and a command/data flag. In read mode the block asks for each outgoing byte with a one-cycle request and shifts that byte out MSB first. It stops transmitting once the master withholds its acknowledge. A transfer-done pulse after each data byte lets the surrounding logic advance its data pointer and subaddress counter.

Top module: `shared_addr_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `011110` followed by `strapLsb`, by pulling SDA low during the ninth clock.
- R2: When the address does not match, the block never pulls SDA low and presents no byte until the next START.
- R3: In a write transfer, every command byte is acknowledged whatever the subaddress selection, and it is presented on `rxByte` with `rxValid` high and `rxIsData` low.
- R4: Bit 7 of a command byte is the continuation flag. When it is 0, every later byte of the transfer is treated as data (`rxIsData` high), even a byte whose bit 7 is 0.
- R5: A data byte is acknowledged and presented only when `selSubaddr` equals `hwSubaddr`. Otherwise SDA stays released and `rxValid` stays low.
- R6: After a matching address with R/W = 1, the block pulses `rdReq` and shifts out the `rdData` byte MSB first. Each later byte is fetched the same way after the master acknowledges the previous one.
- R7: When the master does not acknowledge a read byte, the block releases SDA, issues no further `rdReq`, and a STOP returns it to idle with SDA released.
- R8: A START at any point, even in the middle of a byte, restarts address reception from the first bit.
- R9: `xferDone` pulses once for each data byte that is transferred: each acknowledged write data byte and each read byte.
- R10: After reset the block releases SDA and holds `rxValid`, `rdReq` and `xferDone` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired line) |
| sdaPullLow | output | 1 | 1 = pad pulls SDA low |
| strapLsb | input | 1 | Lowest bit of the slave address |
| hwSubaddr | input | 4 | This device's hardware subaddress |
| selSubaddr | input | 4 | Subaddress currently selected by the command decoder |
| rxValid | output | 1 | One-cycle strobe: a received byte is on rxByte |
| rxByte | output | 8 | Received command or data byte |
| rxIsData | output | 1 | 1 = rxByte is display data, 0 = command |
| xferDone | output | 1 | One-cycle pulse after each transferred data byte |
| rdReq | output | 1 | One-cycle request for the next byte to transmit |
| rdData | input | 8 | Byte to transmit, held from the cycle after rdReq until the next rdReq |

## Verification
Pin changes reach the logic through two synchronizer flops and one edge-detect flop. The strobes `rxValid`, `rdReq` and `xferDone` therefore rise three clock cycles after the SCL rising edge that carries the last bit. SDA starts or stops being pulled three cycles after the SCL falling edge that opens or closes an acknowledge or data bit. The bench holds each SCL phase for twenty cycles and samples SDA halfway through the SCL high phase, well after the three-cycle delay. A monitor process compares each strobe against a scoreboard queue whenever the strobe appears, so no check depends on an exact cycle number. Because every check is sampled on the falling system clock edge, none depends on the order of processes at the rising edge.

// File: rtl/sas_pkg.sv
package sas_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKWAIT,
    ST_ACKDRV,
    ST_TX,
    ST_MACKWAIT,
    ST_MACKSAMP,
    ST_MACKEND,
    ST_SKIP
  } ctlState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaLvl;
  } busEv_t;

endpackage

// File: rtl/sas_datapath.sv
module sas_datapath
  import sas_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(BYTE_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] txData,
  output busEv_t            ev,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxNext,
  output logic              txBit
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxShift, txReg;

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise = sclS & ~sclPrev;
    ev.sclFall = ~sclS & sclPrev;
    ev.start   = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stop    = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sdaLvl  = sdaS;
  end

  assign rxNext = {rxShift[BYTE_W-2:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (ev.sclRise) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (ctl.clrCnt) bitCnt <= '0;
    else if (ev.sclRise) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '1;
    else if (ctl.loadTx) txReg <= txData;
    else if (ctl.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
  end

  assign txBit = txReg[BYTE_W-1];

  // R6
  loadtx_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadTx |-> ev.sclFall);

  // R6
  shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftTx |-> ev.sclFall);

endmodule

// File: rtl/sas_control.sv
module sas_control
  import sas_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SUB_W  = 4,
  parameter int CNT_W  = $clog2(BYTE_W) + 1,
  parameter logic [BYTE_W-3:0] ADDR_HI = 6'b011110
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic              txBit,
  input  logic              strapLsb,
  input  logic [SUB_W-1:0]  hwSubaddr,
  input  logic [SUB_W-1:0]  selSubaddr,
  output dpCtl_t            ctl,
  output logic              sdaPullLow,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxIsData,
  output logic              rdReq,
  output logic              xferDone
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctlState_t state, stateN;
  phase_t phase, phaseN;
  logic rwFlag, rwN, ackFlag, ackN;
  logic rxValidN, rxIsDataN, rdReqN, xferN;
  logic [BYTE_W-1:0] rxByteN;
  logic lastRise, subMatch;

  assign lastRise = ev.sclRise && (bitCnt == LAST_BIT);
  assign subMatch = (selSubaddr == hwSubaddr);

  always_comb begin
    stateN    = state;
    phaseN    = phase;
    rwN       = rwFlag;
    ackN      = ackFlag;
    ctl       = '0;
    rxValidN  = 1'b0;
    rxByteN   = rxByte;
    rxIsDataN = rxIsData;
    rdReqN    = 1'b0;
    xferN     = 1'b0;
    if (ev.stop) begin
      stateN = ST_IDLE;
      ackN   = 1'b0;
    end else if (ev.start) begin
      stateN     = ST_RX;
      phaseN     = PH_ADDR;
      rwN        = 1'b0;
      ackN       = 1'b0;
      ctl.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_RX: begin
          if (lastRise) begin
            case (phase)
              PH_ADDR: begin
                if (rxNext[BYTE_W-1:1] == {ADDR_HI, strapLsb}) begin
                  ackN   = 1'b1;
                  rwN    = rxNext[0];
                  rdReqN = rxNext[0];
                  phaseN = rxNext[0] ? PH_DATA : PH_CMD;
                  stateN = ST_ACKWAIT;
                end else begin
                  stateN = ST_SKIP;
                end
              end
              PH_CMD: begin
                ackN      = 1'b1;
                rxValidN  = 1'b1;
                rxByteN   = rxNext;
                rxIsDataN = 1'b0;
                if (!rxNext[BYTE_W-1]) phaseN = PH_DATA;
                stateN = ST_ACKWAIT;
              end
              default: begin
                ackN      = subMatch;
                rxValidN  = subMatch;
                xferN     = subMatch;
                rxIsDataN = 1'b1;
                if (subMatch) rxByteN = rxNext;
                stateN = ST_ACKWAIT;
              end
            endcase
          end
        end
        ST_ACKWAIT: begin
          if (ev.sclFall) stateN = ST_ACKDRV;
        end
        ST_ACKDRV: begin
          if (ev.sclFall) begin
            ackN       = 1'b0;
            ctl.clrCnt = 1'b1;
            if (rwFlag) begin
              ctl.loadTx = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (lastRise) stateN = ST_MACKWAIT;
          else if (ev.sclFall) ctl.shiftTx = 1'b1;
        end
        ST_MACKWAIT: begin
          if (ev.sclFall) stateN = ST_MACKSAMP;
        end
        ST_MACKSAMP: begin
          if (ev.sclRise) begin
            xferN = 1'b1;
            if (!ev.sdaLvl) begin
              rdReqN = 1'b1;
              stateN = ST_MACKEND;
            end else begin
              stateN = ST_SKIP;
            end
          end
        end
        ST_MACKEND: begin
          if (ev.sclFall) begin
            ctl.loadTx = 1'b1;
            ctl.clrCnt = 1'b1;
            stateN     = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      rwFlag   <= 1'b0;
      ackFlag  <= 1'b0;
      rxValid  <= 1'b0;
      rxByte   <= '0;
      rxIsData <= 1'b0;
      rdReq    <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      state    <= stateN;
      phase    <= phaseN;
      rwFlag   <= rwN;
      ackFlag  <= ackN;
      rxValid  <= rxValidN;
      rxByte   <= rxByteN;
      rxIsData <= rxIsDataN;
      rdReq    <= rdReqN;
      xferDone <= xferN;
    end
  end

  assign sdaPullLow = ((state == ST_ACKDRV) && ackFlag) ||
                      (((state == ST_TX) || (state == ST_MACKWAIT)) && !txBit);

  // R8
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.start |=> (state == ST_RX) && (phase == PH_ADDR) && (bitCnt == '0));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> !sdaPullLow);

  // R5
  data_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxIsData) |-> $past(subMatch));

  // R3
  cmd_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxIsData) |-> ackFlag);

  // R6
  rdreq_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> $past(ev.sclRise));

endmodule

// File: rtl/shared_addr_i2c_slave.sv
module shared_addr_i2c_slave
  import sas_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SUB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-3:0] ADDR_HI = 6'b011110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              strapLsb,
  input  logic [SUB_W-1:0]  hwSubaddr,
  input  logic [SUB_W-1:0]  selSubaddr,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxIsData,
  output logic              xferDone,
  output logic              rdReq,
  input  logic [BYTE_W-1:0] rdData
);

  localparam int CNT_W = $clog2(BYTE_W) + 1;

  dpCtl_t ctl;
  busEv_t ev;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxNext;
  logic txBit;

  sas_datapath #(
    .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .txData(rdData), .ev(ev), .bitCnt(bitCnt),
    .rxNext(rxNext), .txBit(txBit)
  );

  sas_control #(
    .BYTE_W(BYTE_W), .SUB_W(SUB_W), .CNT_W(CNT_W), .ADDR_HI(ADDR_HI)
  ) uCtl (
    .clk(clk), .rstN(rstN), .ev(ev), .bitCnt(bitCnt), .rxNext(rxNext),
    .txBit(txBit), .strapLsb(strapLsb), .hwSubaddr(hwSubaddr),
    .selSubaddr(selSubaddr), .ctl(ctl), .sdaPullLow(sdaPullLow),
    .rxValid(rxValid), .rxByte(rxByte), .rxIsData(rxIsData),
    .rdReq(rdReq), .xferDone(xferDone)
  );

endmodule

// File: tb/shared_addr_i2c_slave_test.sv
`timescale 1ns/1ps
module shared_addr_i2c_slave_test;

  localparam int H = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapLsb = 1'b0;
  logic [3:0] hwSubaddr = 4'h5, selSubaddr = 4'h5;
  logic [7:0] rdData = 8'h00;
  logic sdaPullLow, rxValid, rxIsData, xferDone, rdReq;
  logic [7:0] rxByte;
  logic sdaBus;

  int checks = 0, errors = 0;
  int xferCnt = 0, reqCnt = 0, rdIdx = 0;
  logic [8:0] expQ[$];
  logic [7:0] rdMem[4];
  bit finished = 0;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  shared_addr_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .strapLsb(strapLsb), .hwSubaddr(hwSubaddr),
    .selSubaddr(selSubaddr), .rxValid(rxValid), .rxByte(rxByte),
    .rxIsData(rxIsData), .xferDone(xferDone), .rdReq(rdReq), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard and pulse counters
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        if (expQ.size() == 0) begin
          check(0, "R2/R5 unexpected byte", {rxIsData, rxByte}, 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          check({rxIsData, rxByte} == e, "R3/R4 received byte", {rxIsData, rxByte}, e);
        end
      end
      if (xferDone) xferCnt++;
      if (rdReq) begin
        reqCnt++;
        rdData <= rdMem[rdIdx % 4];
        rdIdx++;
      end
    end
  end

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitH(H);
    sclM = 1'b1; waitH(H);
    sdaM = 1'b0; waitH(H);
    sclM = 1'b0; waitH(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitH(H);
    sclM = 1'b1; waitH(H);
    sdaM = 1'b1; waitH(H);
  endtask

  task automatic clockBit(input logic b);
    sdaM = b; waitH(H);
    sclM = 1'b1; waitH(H);
    sclM = 1'b0; waitH(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
    sdaM = 1'b1; waitH(H);
    sclM = 1'b1; waitH(H / 2);
    acked = !sdaBus;
    waitH(H / 2);
    sclM = 1'b0; waitH(2);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitH(H);
      sclM = 1'b1; waitH(H / 2);
      b = {b[6:0], sdaBus};
      waitH(H / 2);
      sclM = 1'b0; waitH(2);
    end
    sdaM = giveAck ? 1'b0 : 1'b1;
    waitH(H);
    sclM = 1'b1; waitH(H);
    sclM = 1'b0; waitH(2);
    sdaM = 1'b1;
  endtask

  task automatic pushExp(input bit isData, input logic [7:0] b);
    expQ.push_back({isData, b});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    rdMem[0] = 8'hC3; rdMem[1] = 8'h5A; rdMem[2] = 8'h0F; rdMem[3] = 8'h99;
    waitH(10);
    // R10 reset state
    check(sdaPullLow == 0, "R10 sda released", sdaPullLow, 0);
    check(rxValid == 0 && rdReq == 0 && xferDone == 0, "R10 strobes low",
          {rxValid, rdReq, xferDone}, 0);
    rstN = 1'b1;
    waitH(10);
    check(sdaPullLow == 0, "R10 sda after reset", sdaPullLow, 0);

    // write transfer, subaddress selected
    busStart();
    sendByte(8'h78, ack); check(ack, "R1 address ack strap0", ack, 1);
    pushExp(0, 8'h81);
    sendByte(8'h81, ack); check(ack, "R3 command ack", ack, 1);
    pushExp(0, 8'h22);
    sendByte(8'h22, ack); check(ack, "R3 last command ack", ack, 1);
    pushExp(1, 8'hA5);
    sendByte(8'hA5, ack); check(ack, "R5 selected data ack", ack, 1);
    pushExp(1, 8'h3C);
    sendByte(8'h3C, ack); check(ack, "R4 data byte with msb 0 ack", ack, 1);
    busStop();
    check(expQ.size() == 0, "R4 all bytes presented", expQ.size(), 0);
    check(xferCnt == 2, "R9 write data transfers", xferCnt, 2);

    // subaddress not selected: commands acked, data not
    selSubaddr = 4'h3;
    busStart();
    sendByte(8'h78, ack); check(ack, "R1 address ack", ack, 1);
    pushExp(0, 8'h40);
    sendByte(8'h40, ack); check(ack, "R3 command ack unselected", ack, 1);
    sendByte(8'h77, ack); check(!ack, "R5 unselected data nack", ack, 0);
    busStop();
    check(expQ.size() == 0, "R5 queue drained", expQ.size(), 0);
    check(xferCnt == 2, "R9 no transfer on nack", xferCnt, 2);
    selSubaddr = 4'h5;

    // wrong address
    busStart();
    sendByte(8'h7A, ack); check(!ack, "R2 mismatched address nack", ack, 0);
    sendByte(8'h55, ack); check(!ack, "R2 later byte ignored", ack, 0);
    busStop();
    strapLsb = 1'b1;
    busStart();
    sendByte(8'h7A, ack); check(ack, "R1 address ack strap1", ack, 1);
    pushExp(0, 8'h00);
    sendByte(8'h00, ack); check(ack, "R3 command ack strap1", ack, 1);
    busStop();

    // repeated start in mid byte
    busStart();
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1);
    busStart();
    sendByte(8'h7A, ack); check(ack, "R8 restart address ack", ack, 1);
    pushExp(0, 8'h12);
    sendByte(8'h12, ack); check(ack, "R8 command after restart", ack, 1);
    busStop();
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);

    // read transfer
    busStart();
    sendByte(8'h7B, ack); check(ack, "R6 read address ack", ack, 1);
    readByte(1'b1, rb); check(rb == 8'hC3, "R6 first read byte", rb, 8'hC3);
    readByte(1'b0, rb); check(rb == 8'h5A, "R6 second read byte", rb, 8'h5A);
    waitH(H);
    check(sdaBus == 1'b1 && sdaPullLow == 0, "R7 released after nack", sdaBus, 1);
    busStop();
    check(sdaPullLow == 0, "R7 released after stop", sdaPullLow, 0);
    check(reqCnt == 2, "R7 no request after nack", reqCnt, 2);
    check(xferCnt == 4, "R9 read transfers", xferCnt, 4);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule